// File: doc/BRIEF.md
# DMA Burst Bus Request Controller

This block decides when a DMA engine asks for the system bus and how long it keeps it. A two-bit burst code in an 8-bit mode register sets how many transfers one bus ownership may contain. In normal operation the block asks for the bus only when the DMA FIFO has room for, or holds, a whole burst. The FIFO count it looks at depends on the transfer direction. A cleanup indication, used for start-of-transfer and end-of-transfer alignment, forces the request even when less than a full burst is available.

Once the bus is granted, each transfer acknowledge adds one to a per-ownership counter. The request is released when the counter reaches the burst limit, when a cleanup ownership ends early, or at once on an abort or when the remaining byte count reaches zero. Every release is followed by a fixed four-clock gap during which no new request is raised. The limit is captured when a request starts, so a mode register write reaches only the next ownership.

Top module: `dma_burst_req_ctrl`

## Requirements
- R1: The 8-bit mode register resets to 0x00. Every write stores all eight bits, and the written value reads back on `mode_rdata` from the next cycle on.
- R2: Mode bits [7:6] set the per-ownership transfer limit: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16.
- R3: Without cleanup, a request starts only when the selected FIFO count is at least the limit. The selected count is `fifo_fill` when `dir_to_mem` is 1 and `fifo_free` when it is 0. `bus_req_n` goes low in the cycle after the condition is sampled.
- R4: While `cleanup` is 1, a request starts whatever the FIFO counts are.
- R5: Once raised, `bus_req_n` stays low until `bus_grant` is sampled. `xfer_ack` pulses before the grant do not change `xfer_cnt`.
- R6: `xfer_cnt` is cleared when the grant is taken and rises by one for each `xfer_ack` during ownership. `bus_req_n` goes high in the cycle after the acknowledge that brings the count to the limit.
- R7: In an ownership that began with `cleanup` set, dropping `cleanup` releases the request on the next cycle, with fewer transfers than the limit.
- R8: `abort` or `bytes_zero`, sampled while requesting or owning, raises `bus_req_n` on the next cycle. An acknowledge in that same cycle is still counted.
- R9: After every release, `bus_req_n` stays high for at least four cycles. It stays high for exactly four when the request condition holds throughout.
- R10: A mode write during a request or an ownership leaves the limit of that ownership unchanged. The new value applies from the next request.
- R11: `bus_req_n` is 1 and `xfer_cnt` is 0 after reset. While `abort` is held, no new request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register contents |
| dir_to_mem | input | 1 | 1: FIFO drains to memory (uses fill count); 0: FIFO fills from memory (uses free count) |
| fifo_free | input | FIFO_CNT_W | Free entries in the DMA FIFO |
| fifo_fill | input | FIFO_CNT_W | Filled entries in the DMA FIFO |
| cleanup | input | 1 | Start/end-of-transfer alignment cleanup in progress |
| abort | input | 1 | Transfer aborted |
| bytes_zero | input | 1 | Remaining byte count reached zero |
| bus_grant | input | 1 | Bus granted to this engine |
| xfer_ack | input | 1 | One transfer acknowledged on the bus |
| bus_req_n | output | 1 | Active-low bus request |
| xfer_cnt | output | 5 | Transfers done in the current or last ownership |

## Verification
The collision of interest is the acknowledge that completes a transfer arriving in the same cycle as an abort. Both paths end the ownership, and the count must still include that acknowledge. A directed case drives `xfer_ack` and `abort` together in mid-burst and expects the request released, the count one higher and a full four-cycle gap afterwards. Random stimulus also lands mode writes on the very cycle a request starts, and there the bench model expects the old burst code to be captured.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  localparam int LIM_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_GAP  = 2'd3
  } dbr_state_e;

  function automatic logic [LIM_W-1:0] burst_limit(input logic [1:0] code);
    burst_limit = LIM_W'(5'd2 << code);
  endfunction

endpackage

// File: rtl/dbr_rst_sync.sv
module dbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dbr_mode_reg.sv
module dbr_mode_reg #(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] rd_data
);

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_d;
  logic              mode_en;

  always_comb begin
    mode_en = wr_en;
    mode_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign rd_data = mode_q;

  // R1
  mode_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/dbr_room_chk.sv
module dbr_room_chk #(
  parameter int FIFO_CNT_W = 5,
  parameter int LIM_W      = 5
) (
  input  logic                  dir_to_mem,
  input  logic [FIFO_CNT_W-1:0] fifo_free,
  input  logic [FIFO_CNT_W-1:0] fifo_fill,
  input  logic [LIM_W-1:0]      limit,
  input  logic                  cleanup,
  output logic                  want
);

  logic [FIFO_CNT_W-1:0] sel_cnt;
  logic                  room_ok;

  always_comb begin
    sel_cnt = dir_to_mem ? fifo_fill : fifo_free;
    room_ok = (32'(sel_cnt) >= 32'(limit));
    want    = cleanup | room_ok;
  end

endmodule

// File: rtl/dbr_gap_timer.sv
module dbr_gap_timer #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);

  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] LOAD_VAL = GW'(GAP_CYC - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          tmr_en;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    tmr_en = start | act_q;
    if (start) begin
      cnt_d = LOAD_VAL;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (tmr_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign last   = act_q & (cnt_q == '0);

  // R9
  gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && (cnt_q == LOAD_VAL)));

endmodule

// File: rtl/dma_burst_req_ctrl.sv
module dma_burst_req_ctrl #(
  parameter int FIFO_CNT_W = 5,
  parameter int GAP_CYC    = 4,
  parameter int MODE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr,
  input  logic [MODE_W-1:0]     mode_wdata,
  output logic [MODE_W-1:0]     mode_rdata,
  input  logic                  dir_to_mem,
  input  logic [FIFO_CNT_W-1:0] fifo_free,
  input  logic [FIFO_CNT_W-1:0] fifo_fill,
  input  logic                  cleanup,
  input  logic                  abort,
  input  logic                  bytes_zero,
  input  logic                  bus_grant,
  input  logic                  xfer_ack,
  output logic                  bus_req_n,
  output logic [4:0]            xfer_cnt
);

  import dbr_pkg::*;

  localparam int BL_HI = 7;
  localparam int BL_LO = 6;

  logic             rst_q;
  logic [MODE_W-1:0] mode_q;
  logic [LIM_W-1:0] lim_new;
  logic             want;
  logic             gap_start, gap_active, gap_last;

  dbr_state_e       st_q, st_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             lim_en;
  logic             cln_q, cln_d;
  logic [LIM_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;
  logic             stop, launch, at_limit, cln_done;

  dbr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_q)
  );

  dbr_mode_reg #(.MODE_W(MODE_W)) u_mode_reg (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (mode_wr),
    .wr_data (mode_wdata),
    .rd_data (mode_q)
  );

  assign lim_new = burst_limit(mode_q[BL_HI:BL_LO]);

  dbr_room_chk #(.FIFO_CNT_W(FIFO_CNT_W), .LIM_W(LIM_W)) u_room_chk (
    .dir_to_mem (dir_to_mem),
    .fifo_free  (fifo_free),
    .fifo_fill  (fifo_fill),
    .limit      (lim_new),
    .cleanup    (cleanup),
    .want       (want)
  );

  dbr_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap_timer (
    .clk    (clk),
    .rst_n  (rst_q),
    .start  (gap_start),
    .active (gap_active),
    .last   (gap_last)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    lim_d     = lim_q;
    lim_en    = 1'b0;
    cln_d     = cln_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    gap_start = 1'b0;
    stop      = abort | bytes_zero;
    launch    = want & ~abort;
    cnt_inc   = cnt_q + 1'b1;
    at_limit  = xfer_ack & (cnt_inc == lim_q);
    cln_done  = cln_q & ~cleanup;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_d   = ST_REQ;
          lim_d  = lim_new;
          cln_d  = cleanup;
          lim_en = 1'b1;
        end
      end
      ST_REQ: begin
        if (stop) begin
          st_d      = ST_GAP;
          gap_start = 1'b1;
        end else if (bus_grant) begin
          st_d   = ST_OWN;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_OWN: begin
        if (xfer_ack) begin
          cnt_d  = cnt_inc;
          cnt_en = 1'b1;
        end
        if (stop | at_limit | cln_done) begin
          st_d      = ST_GAP;
          gap_start = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_last) begin
          if (launch) begin
            st_d   = ST_REQ;
            lim_d  = lim_new;
            cln_d  = cleanup;
            lim_en = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lim_q <= '0;
      cln_q <= 1'b0;
    end else if (lim_en) begin
      lim_q <= lim_d;
      cln_q <= cln_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign bus_req_n  = ~((st_q == ST_REQ) | (st_q == ST_OWN));
  assign xfer_cnt   = cnt_q;
  assign mode_rdata = mode_q;

  // checker state: high-run length of the request and whether one was seen
  logic [2:0] hi_run_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hi_run_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (!bus_req_n) begin
        hi_run_q <= '0;
        seen_q   <= 1'b1;
      end else if (hi_run_q != 3'd7) begin
        hi_run_q <= hi_run_q + 1'b1;
      end
    end
  end

  // R9
  fair_gap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (seen_q && $fell(bus_req_n)) |-> (32'(hi_run_q) >= GAP_CYC));

  // R9
  gap_state_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_GAP) |-> gap_active);

  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((st_q == ST_REQ) && !bus_grant && !stop) |=> !bus_req_n);

  // R6
  limit_release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((st_q == ST_OWN) && xfer_ack && (cnt_inc == lim_q)) |=> bus_req_n);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_OWN) |-> (cnt_q < lim_q));

  // R8
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!bus_req_n && (abort || bytes_zero)) |=> bus_req_n);

  // R10
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((st_q == ST_OWN) && ($past(st_q) == ST_OWN)) |-> $stable(lim_q));

  // R11
  abort_block_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_req_n && abort) |=> bus_req_n);

endmodule

// File: tb/dma_burst_req_ctrl_tb.sv
module dma_burst_req_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [7:0] mode_wdata;
  logic [7:0] mode_rdata;
  logic       dir_to_mem;
  logic [4:0] fifo_free;
  logic [4:0] fifo_fill;
  logic       cleanup;
  logic       abort;
  logic       bytes_zero;
  logic       bus_grant;
  logic       xfer_ack;
  logic       bus_req_n;
  logic [4:0] xfer_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dma_burst_req_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .dir_to_mem (dir_to_mem),
    .fifo_free  (fifo_free),
    .fifo_fill  (fifo_fill),
    .cleanup    (cleanup),
    .abort      (abort),
    .bytes_zero (bytes_zero),
    .bus_grant  (bus_grant),
    .xfer_ack   (xfer_ack),
    .bus_req_n  (bus_req_n),
    .xfer_cnt   (xfer_cnt)
  );

  // reference model: 0 idle, 1 requesting, 2 owning, 3 gap
  int       m_st, m_lim, m_cnt, m_gap;
  bit       m_cln;
  bit [7:0] m_mode;

  function automatic int lim_of(input bit [1:0] code);
    return 2 << code;
  endfunction

  function automatic bit m_req_n();
    return !(m_st == 1 || m_st == 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit want, launch, stop;
    int sel;
    sel    = dir_to_mem ? int'(fifo_fill) : int'(fifo_free);
    want   = cleanup || (sel >= lim_of(m_mode[7:6]));
    launch = want && !abort;
    stop   = abort || bytes_zero;
    case (m_st)
      0: if (launch) begin m_st = 1; m_lim = lim_of(m_mode[7:6]); m_cln = cleanup; end
      1: if (stop) begin m_st = 3; m_gap = 3; end
         else if (bus_grant) begin m_st = 2; m_cnt = 0; end
      2: begin
        bit rel;
        rel = stop || (xfer_ack && (m_cnt + 1 == m_lim)) || (m_cln && !cleanup);
        if (xfer_ack) m_cnt = m_cnt + 1;
        if (rel) begin m_st = 3; m_gap = 3; end
      end
      default: begin
        if (m_gap == 0) begin
          if (launch) begin m_st = 1; m_lim = lim_of(m_mode[7:6]); m_cln = cleanup; end
          else m_st = 0;
        end else m_gap = m_gap - 1;
      end
    endcase
    if (mode_wr) m_mode = mode_wdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R3 model bus_req_n", int'(bus_req_n), int'(m_req_n()));
    chk("R6 model xfer_cnt", int'(xfer_cnt), m_cnt);
    chk("R1 model mode_rdata", int'(mode_rdata), int'(m_mode));
  endtask

  task automatic wait_req_low(input string req);
    for (int i = 0; i < 12 && bus_req_n; i++) step();
    chk(req, int'(bus_req_n), 0);
  endtask

  initial begin
    int hi;
    rst_n = 1'b0; mode_wr = 0; mode_wdata = 0; dir_to_mem = 0;
    fifo_free = 0; fifo_fill = 0; cleanup = 0; abort = 0;
    bytes_zero = 0; bus_grant = 0; xfer_ack = 0;
    m_st = 0; m_lim = 2; m_cnt = 0; m_gap = 0; m_cln = 0; m_mode = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R11 / R1 reset state
    chk("R11 reset bus_req_n", int'(bus_req_n), 1);
    chk("R11 reset xfer_cnt", int'(xfer_cnt), 0);
    chk("R1 reset mode", int'(mode_rdata), 0);

    // R1 write/read, burst code 10
    mode_wr = 1; mode_wdata = 8'hA5; step(); mode_wr = 0;
    chk("R1 readback", int'(mode_rdata), 8'hA5);

    // R3 room threshold, direction selects fill count
    dir_to_mem = 1; fifo_fill = 7; fifo_free = 31;
    step(); step();
    chk("R3 fill below limit", int'(bus_req_n), 1);
    fifo_fill = 8; step();
    chk("R3 fill at limit", int'(bus_req_n), 0);

    // R5 acks before grant ignored, request held
    xfer_ack = 1; step(); step(); xfer_ack = 0;
    chk("R5 held before grant", int'(bus_req_n), 0);
    chk("R5 ack before grant", int'(xfer_cnt), 0);

    // R10 write during request, code 00
    mode_wr = 1; mode_wdata = 8'h05; step(); mode_wr = 0;
    bus_grant = 1; step(); bus_grant = 0;
    xfer_ack = 1;
    repeat (7) step();
    chk("R6 count mid burst", int'(xfer_cnt), 7);
    chk("R10 still owning", int'(bus_req_n), 0);
    step(); xfer_ack = 0;
    chk("R2 code10 limit 8", int'(xfer_cnt), 8);
    chk("R6 release at limit", int'(bus_req_n), 1);

    // R9 exact gap with condition held
    hi = 1;
    for (int i = 0; i < 10 && bus_req_n; i++) begin step(); if (bus_req_n) hi++; end
    chk("R9 gap length", hi, 4);

    // R2 code 00 limit 2 (R10 new value applies)
    bus_grant = 1; step(); bus_grant = 0;
    xfer_ack = 1; step(); step(); xfer_ack = 0;
    chk("R2 code00 limit 2", int'(xfer_cnt), 2);
    chk("R10 new limit used", int'(bus_req_n), 1);

    // R4 cleanup forces request; R7 early release
    fifo_fill = 0; fifo_free = 0; dir_to_mem = 0; cleanup = 1;
    wait_req_low("R4 cleanup request");
    bus_grant = 1; step(); bus_grant = 0;
    xfer_ack = 1; step(); xfer_ack = 0;
    cleanup = 0; step();
    chk("R7 cleanup release", int'(bus_req_n), 1);
    chk("R7 short count", int'(xfer_cnt), 1);

    // R8 abort together with an ack, code 11
    mode_wr = 1; mode_wdata = 8'hC0; step(); mode_wr = 0;
    dir_to_mem = 1; fifo_fill = 16;
    wait_req_low("R3 request limit 16");
    bus_grant = 1; step(); bus_grant = 0;
    xfer_ack = 1; step();
    abort = 1; step(); abort = 0; xfer_ack = 0;
    chk("R8 abort drop", int'(bus_req_n), 1);
    chk("R8 ack counted", int'(xfer_cnt), 2);

    // R11 abort held blocks request
    abort = 1;
    hi = 0;
    for (int i = 0; i < 8; i++) begin step(); if (!bus_req_n) hi++; end
    chk("R11 abort blocks", hi, 0);
    abort = 0;

    // R8 bytes_zero while requesting
    wait_req_low("R3 request again");
    bytes_zero = 1; step(); bytes_zero = 0;
    chk("R8 bytes_zero drop", int'(bus_req_n), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      mode_wr    = ($urandom % 16) == 0;
      mode_wdata = 8'($urandom);
      if (($urandom % 64) == 0) dir_to_mem = ~dir_to_mem;
      if (($urandom % 8) == 0) fifo_fill = 5'($urandom);
      if (($urandom % 8) == 0) fifo_free = 5'($urandom);
      if (($urandom % 40) == 0) cleanup = ~cleanup;
      abort      = ($urandom % 50) == 0;
      bytes_zero = ($urandom % 60) == 0;
      bus_grant  = ($urandom % 4) == 0;
      xfer_ack   = ($urandom % 2) == 0;
      step();
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule